// File: doc/BRIEF.md
# Register-Window AXI4-Lite Master Bridge

This block lets a narrow host bus with 16-bit registers run single 32-bit AXI4-Lite transactions. The host fills the target address and, for a write, the data, one 16-bit half at a time. It then writes a command code into the control register. The bridge drives exactly one AXI4-Lite write or read. It stores the returned read data as two 16-bit halves and records the outcome as sticky event flags. One command is in flight at a time, and a hardware cycle counter stops a transaction whose response never arrives.

Each event (read done, write done, timeout, error response, external AXI interrupt) has its own enable bit. An event is recorded only while its enable is set. The host clears recorded events by writing ones to them. A single interrupt output is high while any recorded event still has its enable set. Optional post-increment commands step the stored address by one 32-bit word after a clean completion, so that consecutive words can be streamed with one command write each.

Top module: `regbridge_axil_master`

## Requirements
- R1: After reset the status register (index 0) reads 0x0020: only the initialisation-done bit 5 is set. The interrupt output is low and no AXI valid is asserted.
- R2: The eight registers are selected by a 3-bit index: 0 status, 1 control, 2 address low, 3 address high, 4 write data low, 5 write data high, 6 read data low, 7 read data high. A read returns the register on the cycle after the index is presented. Control reads back its enables in bits 15..11 and zeros elsewhere.
- R3: Writing command 0x8 (write) or 0x9 in control bits 3..0 issues one AXI write. The address is {index3, index2}, the data is {index5, index4} and all byte strobes are set. An OKAY response sets status bit 14 (write done).
- R4: Command 0xA (read) or 0xB issues one AXI read. On an OKAY response the data is stored as low half in index 6 and high half in index 7, and status bits 15 (read done) and 7 (read data available) are set. Reading index 7 clears bit 7.
- R5: Commands 0x9 and 0xB add 4 to the 32-bit stored address after an OKAY response, with the carry passed from the low half into the high half. Commands 0x8 and 0xA leave the address unchanged.
- R6: A non-zero BRESP or RRESP (SLVERR or DECERR) sets status bit 12 (error) and sets no done bit. It applies no post-increment and leaves index 6 and 7 unchanged.
- R7: If no response arrives within TMO_CYCLES cycles of acceptance, the bridge drops its valid signals, returns to idle and sets status bit 13 (timeout).
- R8: Status bit 6 (busy) is high from the accepted command until the response or the timeout. A command written while busy starts no transaction.
- R9: Writing status with a 1 in any of bits 15..11 clears that event. Writing 0 to an event bit leaves it unchanged.
- R10: An event is recorded only while its enable bit is set (control bit 15..11 for status bit 15..11).
- R11: The interrupt output is high exactly when a recorded event bit 15..11 has its enable bit still set.
- R12: While the external interrupt input is high and enable bit 11 is set, status bit 11 is set, and it stays set after the input falls.
- R13: Command codes outside 0x8..0xB (for example 0x0 or 0xC) start no transaction and do not set busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_sel | input | 1 | Host access strobe, one cycle per access |
| hst_wr | input | 1 | 1 = host write, 0 = host read |
| hst_idx | input | 3 | Register index |
| hst_wdata | input | REG_W | Host write data |
| hst_rdata | output | REG_W | Registered host read data |
| ext_irq | input | 1 | Interrupt level from the AXI side |
| irq | output | 1 | Combined interrupt |
| m_awaddr | output | 2*REG_W | AXI write address |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_wdata | output | 2*REG_W | AXI write data |
| m_wstrb | output | 2*REG_W/8 | Write byte strobes |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bresp | input | 2 | Write response |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_araddr | output | 2*REG_W | AXI read address |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_rdata | input | 2*REG_W | Read data |
| m_rresp | input | 2 | Read response |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |

## Verification
The main path is swept over all four commands and slave response latencies of 0 to 3 cycles at sixteen word addresses, each with distinct data in both halves. This separates a swapped or misplaced half, a wrong latency assumption, and a post-increment applied to the wrong command. A low-half address of 0xFFFC exposes a missing carry into the high half. SLVERR and DECERR responses separate error recording from completion. A silent slave exposes the timeout and, during it, a command that must be ignored. Enable, clear and interrupt patterns set two events together and clear them one at a time, which shows whether the write-one clear and the interrupt gating act per bit.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  // number of sticky events, which sit at status bits 15..11
  localparam int EV_N = 5;
  // index of each event inside the event vector (vector bit g = status bit 11+g)
  localparam int EV_XINT = 0;
  localparam int EV_ERR  = 1;
  localparam int EV_TMO  = 2;
  localparam int EV_WRD  = 3;
  localparam int EV_RDD  = 4;
  // status flag positions
  localparam int ST_RDAV = 7;
  localparam int ST_BUSY = 6;
  localparam int ST_INIT = 5;
  // command bits 3..2 equal to this start a transfer; bit 1 = read, bit 0 = step
  localparam logic [1:0] CMD_GO = 2'b10;

  typedef enum logic [2:0] {
    RI_STAT = 3'd0, RI_CTRL = 3'd1, RI_ALO = 3'd2, RI_AHI = 3'd3,
    RI_WLO  = 3'd4, RI_WHI  = 3'd5, RI_RLO = 3'd6, RI_RHI = 3'd7
  } reg_idx_t;

  typedef enum logic [2:0] {
    ENG_IDLE, ENG_WREQ, ENG_WRSP, ENG_RREQ, ENG_RRSP
  } eng_state_t;
endpackage

// File: rtl/bridge_watchdog.sv
module bridge_watchdog #(
  parameter int LIMIT = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expire
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  assign expire = run && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (!expire) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/bridge_axi_engine.sv
module bridge_axi_engine
  import bridge_pkg::*;
#(
  parameter int AXI_W      = 32,
  parameter int TMO_CYCLES = 256
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               start_rd,
  input  logic [AXI_W-1:0]   start_addr,
  input  logic [AXI_W-1:0]   start_data,
  output logic               busy,
  output logic               fin_ok,
  output logic               fin_err,
  output logic               fin_tmo,
  output logic               fin_rd,
  output logic [AXI_W-1:0]   m_awaddr,
  output logic               m_awvalid,
  input  logic               m_awready,
  output logic [AXI_W-1:0]   m_wdata,
  output logic [AXI_W/8-1:0] m_wstrb,
  output logic               m_wvalid,
  input  logic               m_wready,
  input  logic [1:0]         m_bresp,
  input  logic               m_bvalid,
  output logic               m_bready,
  output logic [AXI_W-1:0]   m_araddr,
  output logic               m_arvalid,
  input  logic               m_arready,
  input  logic [1:0]         m_rresp,
  input  logic               m_rvalid,
  output logic               m_rready
);
  localparam int STRB_W = AXI_W / 8;

  eng_state_t       st_q;
  logic             aw_q, w_q, ar_q;
  logic [AXI_W-1:0] addr_q, data_q;
  logic             expire;
  logic             resp_hs;
  logic [1:0]       resp;

  bridge_watchdog #(.LIMIT(TMO_CYCLES)) u_wdog (
    .clk    (clk),
    .rst    (rst),
    .run    (busy),
    .expire (expire)
  );

  assign busy      = (st_q != ENG_IDLE);
  assign m_awaddr  = addr_q;
  assign m_araddr  = addr_q;
  assign m_wdata   = data_q;
  assign m_wstrb   = {STRB_W{1'b1}};
  assign m_awvalid = aw_q;
  assign m_wvalid  = w_q;
  assign m_arvalid = ar_q;
  assign m_bready  = (st_q == ENG_WRSP);
  assign m_rready  = (st_q == ENG_RRSP);

  always_comb begin
    resp_hs = (m_bready && m_bvalid) || (m_rready && m_rvalid);
    resp    = (st_q == ENG_WRSP) ? m_bresp : m_rresp;
    fin_ok  = resp_hs && (resp == 2'b00);
    fin_err = resp_hs && (resp != 2'b00);
    fin_tmo = expire && !resp_hs;
    fin_rd  = (st_q == ENG_RREQ) || (st_q == ENG_RRSP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ENG_IDLE;
      aw_q   <= 1'b0;
      w_q    <= 1'b0;
      ar_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (st_q == ENG_IDLE) begin
      if (start) begin
        addr_q <= start_addr;
        data_q <= start_data;
        if (start_rd) begin
          st_q <= ENG_RREQ;
          ar_q <= 1'b1;
        end else begin
          st_q <= ENG_WREQ;
          aw_q <= 1'b1;
          w_q  <= 1'b1;
        end
      end
    end else if (resp_hs) begin
      st_q <= ENG_IDLE;
    end else if (expire) begin
      st_q <= ENG_IDLE;
      aw_q <= 1'b0;
      w_q  <= 1'b0;
      ar_q <= 1'b0;
    end else begin
      case (st_q)
        ENG_WREQ: begin
          aw_q <= aw_q && !m_awready;
          w_q  <= w_q && !m_wready;
          if ((!aw_q || m_awready) && (!w_q || m_wready)) st_q <= ENG_WRSP;
        end
        ENG_RREQ: begin
          if (m_arready) begin
            ar_q <= 1'b0;
            st_q <= ENG_RRSP;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bridge_hostregs.sv
module bridge_hostregs
  import bridge_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel,
  input  logic               wr,
  input  logic [2:0]         idx,
  input  logic [REG_W-1:0]   wdata,
  output logic [REG_W-1:0]   rdata,
  input  logic               eng_busy,
  input  logic               fin_ok,
  input  logic               fin_err,
  input  logic               fin_tmo,
  input  logic               fin_rd,
  input  logic [2*REG_W-1:0] axi_rdata,
  input  logic               ext_irq,
  output logic               start,
  output logic               start_rd,
  output logic [2*REG_W-1:0] tx_addr,
  output logic [2*REG_W-1:0] tx_data,
  output logic               irq,
  output logic [EV_N-1:0]    ev_q,
  output logic [EV_N-1:0]    en_q
);
  localparam int AXI_W  = 2 * REG_W;
  localparam int EV_LSB = REG_W - EV_N;

  logic [REG_W-1:0] addr_lo, addr_hi, wd_lo, wd_hi, rd_lo, rd_hi;
  logic             rdav_q, init_q, step_q;
  logic             wr_hit, rd_hit, ctl_wr, st_wr;
  logic [EV_N-1:0]  ev_raw, ev_nx, en_nx;
  logic [REG_W-1:0] st_word, rd_mux;

  always_comb begin
    wr_hit   = sel && wr;
    rd_hit   = sel && !wr;
    ctl_wr   = wr_hit && (idx == RI_CTRL);
    st_wr    = wr_hit && (idx == RI_STAT);
    start    = ctl_wr && (wdata[3:2] == CMD_GO) && !eng_busy;
    start_rd = wdata[1];
    tx_addr  = {addr_hi, addr_lo};
    tx_data  = {wd_hi, wd_lo};
    en_nx    = ctl_wr ? wdata[REG_W-1:EV_LSB] : en_q;
  end

  // raw event sources in event-vector order
  assign ev_raw[EV_XINT] = ext_irq;
  assign ev_raw[EV_ERR]  = fin_err;
  assign ev_raw[EV_TMO]  = fin_tmo;
  assign ev_raw[EV_WRD]  = fin_ok && !fin_rd;
  assign ev_raw[EV_RDD]  = fin_ok && fin_rd;

  for (genvar g = 0; g < EV_N; g++) begin : g_ev
    assign ev_nx[g] = (ev_q[g] && !(st_wr && wdata[EV_LSB+g])) || (ev_raw[g] && en_q[g]);
  end

  always_comb begin
    st_word          = '0;
    st_word[REG_W-1:EV_LSB] = ev_q;
    st_word[ST_RDAV] = rdav_q;
    st_word[ST_BUSY] = eng_busy;
    st_word[ST_INIT] = init_q;
    case (idx)
      RI_STAT: rd_mux = st_word;
      RI_CTRL: rd_mux = {en_q, {EV_LSB{1'b0}}};
      RI_ALO:  rd_mux = addr_lo;
      RI_AHI:  rd_mux = addr_hi;
      RI_WLO:  rd_mux = wd_lo;
      RI_WHI:  rd_mux = wd_hi;
      RI_RLO:  rd_mux = rd_lo;
      default: rd_mux = rd_hi;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_lo <= '0;
      addr_hi <= '0;
      wd_lo   <= '0;
      wd_hi   <= '0;
      rd_lo   <= '0;
      rd_hi   <= '0;
      ev_q    <= '0;
      en_q    <= '0;
      rdav_q  <= 1'b0;
      init_q  <= 1'b0;
      step_q  <= 1'b0;
      irq     <= 1'b0;
      rdata   <= '0;
    end else begin
      init_q <= 1'b1;
      ev_q   <= ev_nx;
      en_q   <= en_nx;
      irq    <= |(ev_nx & en_nx);
      rdata  <= rd_mux;
      if (start) step_q <= wdata[0];
      if (wr_hit) begin
        case (idx)
          RI_ALO:  addr_lo <= wdata;
          RI_AHI:  addr_hi <= wdata;
          RI_WLO:  wd_lo   <= wdata;
          RI_WHI:  wd_hi   <= wdata;
          default: ;
        endcase
      end
      if (fin_ok && step_q) {addr_hi, addr_lo} <= {addr_hi, addr_lo} + AXI_W'(4);
      if (fin_ok && fin_rd) begin
        {rd_hi, rd_lo} <= axi_rdata;
        rdav_q         <= 1'b1;
      end else if (rd_hit && (idx == RI_RHI)) begin
        rdav_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/regbridge_axil_master.sv
module regbridge_axil_master
  import bridge_pkg::*;
#(
  parameter int REG_W      = 16,
  parameter int TMO_CYCLES = 256
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 hst_sel,
  input  logic                 hst_wr,
  input  logic [2:0]           hst_idx,
  input  logic [REG_W-1:0]     hst_wdata,
  output logic [REG_W-1:0]     hst_rdata,
  input  logic                 ext_irq,
  output logic                 irq,
  output logic [2*REG_W-1:0]   m_awaddr,
  output logic                 m_awvalid,
  input  logic                 m_awready,
  output logic [2*REG_W-1:0]   m_wdata,
  output logic [2*REG_W/8-1:0] m_wstrb,
  output logic                 m_wvalid,
  input  logic                 m_wready,
  input  logic [1:0]           m_bresp,
  input  logic                 m_bvalid,
  output logic                 m_bready,
  output logic [2*REG_W-1:0]   m_araddr,
  output logic                 m_arvalid,
  input  logic                 m_arready,
  input  logic [2*REG_W-1:0]   m_rdata,
  input  logic [1:0]           m_rresp,
  input  logic                 m_rvalid,
  output logic                 m_rready
);
  localparam int AXI_W = 2 * REG_W;

  logic             eng_busy, fin_ok, fin_err, fin_tmo, fin_rd;
  logic             start, start_rd;
  logic [AXI_W-1:0] tx_addr, tx_data;
  logic [EV_N-1:0]  ev_bits, en_bits;

  bridge_hostregs #(.REG_W(REG_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .sel       (hst_sel),
    .wr        (hst_wr),
    .idx       (hst_idx),
    .wdata     (hst_wdata),
    .rdata     (hst_rdata),
    .eng_busy  (eng_busy),
    .fin_ok    (fin_ok),
    .fin_err   (fin_err),
    .fin_tmo   (fin_tmo),
    .fin_rd    (fin_rd),
    .axi_rdata (m_rdata),
    .ext_irq   (ext_irq),
    .start     (start),
    .start_rd  (start_rd),
    .tx_addr   (tx_addr),
    .tx_data   (tx_data),
    .irq       (irq),
    .ev_q      (ev_bits),
    .en_q      (en_bits)
  );

  bridge_axi_engine #(.AXI_W(AXI_W), .TMO_CYCLES(TMO_CYCLES)) u_eng (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .start_rd   (start_rd),
    .start_addr (tx_addr),
    .start_data (tx_data),
    .busy       (eng_busy),
    .fin_ok     (fin_ok),
    .fin_err    (fin_err),
    .fin_tmo    (fin_tmo),
    .fin_rd     (fin_rd),
    .m_awaddr   (m_awaddr),
    .m_awvalid  (m_awvalid),
    .m_awready  (m_awready),
    .m_wdata    (m_wdata),
    .m_wstrb    (m_wstrb),
    .m_wvalid   (m_wvalid),
    .m_wready   (m_wready),
    .m_bresp    (m_bresp),
    .m_bvalid   (m_bvalid),
    .m_bready   (m_bready),
    .m_araddr   (m_araddr),
    .m_arvalid  (m_arvalid),
    .m_arready  (m_arready),
    .m_rresp    (m_rresp),
    .m_rvalid   (m_rvalid),
    .m_rready   (m_rready)
  );
endmodule

// File: rtl/bridge_checker.sv
module bridge_checker #(
  parameter int AXI_W      = 32,
  parameter int EVN        = 5,
  parameter int TMO_CYCLES = 256
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             fin_tmo,
  input logic [EVN-1:0]   ev,
  input logic             irq,
  input logic             awvalid,
  input logic             awready,
  input logic [AXI_W-1:0] awaddr,
  input logic             wvalid,
  input logic             arvalid,
  input logic             arready,
  input logic [AXI_W-1:0] araddr,
  input logic             bvalid,
  input logic             bready,
  input logic [1:0]       bresp,
  input logic             rvalid,
  input logic             rready,
  input logic [1:0]       rresp
);
  localparam int CW = $clog2(TMO_CYCLES + 2);

  logic [CW-1:0] busy_run;

  always_ff @(posedge clk) begin
    if (rst) busy_run <= '0;
    else     busy_run <= busy ? busy_run + 1'b1 : '0;
  end

  AST_AW_HOLD: assert property (@(posedge clk) disable iff (rst)
    (awvalid && !awready && !fin_tmo) |=> (awvalid && $stable(awaddr))); // R3
  AST_AR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (arvalid && !arready && !fin_tmo) |=> (arvalid && $stable(araddr))); // R4
  AST_ONE_KIND: assert property (@(posedge clk) disable iff (rst)
    !(arvalid && (awvalid || wvalid))); // R8
  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy_run <= CW'(TMO_CYCLES)); // R7
  AST_WRD_OKAY: assert property (@(posedge clk) disable iff (rst)
    $rose(ev[3]) |-> $past(bvalid && bready && (bresp == 2'b00))); // R3
  AST_ERR_RESP: assert property (@(posedge clk) disable iff (rst)
    $rose(ev[1]) |-> $past((bvalid && bready && (bresp != 2'b00)) ||
                           (rvalid && rready && (rresp != 2'b00)))); // R6
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
    irq |-> (ev != '0)); // R11
endmodule

bind regbridge_axil_master bridge_checker #(
  .AXI_W(2 * REG_W), .EVN(bridge_pkg::EV_N), .TMO_CYCLES(TMO_CYCLES)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .busy    (eng_busy),
  .fin_tmo (fin_tmo),
  .ev      (ev_bits),
  .irq     (irq),
  .awvalid (m_awvalid),
  .awready (m_awready),
  .awaddr  (m_awaddr),
  .wvalid  (m_wvalid),
  .arvalid (m_arvalid),
  .arready (m_arready),
  .araddr  (m_araddr),
  .bvalid  (m_bvalid),
  .bready  (m_bready),
  .bresp   (m_bresp),
  .rvalid  (m_rvalid),
  .rready  (m_rready),
  .rresp   (m_rresp)
);

// File: tb/regbridge_axil_master_tb.sv
module regbridge_axil_master_tb;
  localparam int TMO = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hst_sel = 1'b0, hst_wr = 1'b0;
  logic [2:0]  hst_idx = '0;
  logic [15:0] hst_wdata = '0;
  logic [15:0] hst_rdata;
  logic        ext_irq = 1'b0;
  logic        irq;
  logic [31:0] m_awaddr, m_wdata, m_araddr;
  logic [31:0] m_rdata = '0;
  logic [3:0]  m_wstrb;
  logic        m_awvalid, m_wvalid, m_bready, m_arvalid, m_rready;
  logic        m_bvalid = 1'b0, m_rvalid = 1'b0;
  logic [1:0]  m_bresp = '0, m_rresp = '0;

  always #10 clk = ~clk;

  regbridge_axil_master #(.REG_W(16), .TMO_CYCLES(TMO)) u_dut (
    .clk(clk), .rst(rst), .hst_sel(hst_sel), .hst_wr(hst_wr), .hst_idx(hst_idx),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .ext_irq(ext_irq), .irq(irq),
    .m_awaddr(m_awaddr), .m_awvalid(m_awvalid), .m_awready(1'b1),
    .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wvalid(m_wvalid), .m_wready(1'b1),
    .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready),
    .m_araddr(m_araddr), .m_arvalid(m_arvalid), .m_arready(1'b1),
    .m_rdata(m_rdata), .m_rresp(m_rresp), .m_rvalid(m_rvalid), .m_rready(m_rready)
  );

  // ---------------- slave model ----------------
  int          sl_lat = 0;
  logic [1:0]  sl_resp = 2'b00;
  logic        sl_mute = 1'b0;
  int          aw_cnt = 0, ar_cnt = 0;
  logic [31:0] mem [16];
  logic [31:0] exp_mem [16];
  logic        got_aw = 0, got_w = 0, got_ar = 0;
  logic [31:0] cap_aw, cap_w, cap_ar, last_aw, last_w;
  int          wcd = 0, rcd = 0;

  always @(posedge clk) begin
    if (m_awvalid) begin got_aw <= 1; cap_aw <= m_awaddr; last_aw <= m_awaddr; aw_cnt <= aw_cnt + 1; wcd <= sl_lat; end
    if (m_wvalid)  begin got_w <= 1; cap_w <= m_wdata; last_w <= m_wdata; end
    if (got_aw && got_w && !m_bvalid) begin
      if (wcd == 0) begin
        m_bvalid <= 1; m_bresp <= sl_resp;
        if (sl_resp == 2'b00) mem[cap_aw[5:2]] <= cap_w;
        got_aw <= 0; got_w <= 0;
      end else wcd <= wcd - 1;
    end
    if (m_bvalid && m_bready) m_bvalid <= 0;
    if (m_arvalid) begin got_ar <= 1; cap_ar <= m_araddr; ar_cnt <= ar_cnt + 1; rcd <= sl_lat; end
    if (got_ar && !m_rvalid) begin
      if (rcd == 0) begin
        m_rvalid <= 1; m_rresp <= sl_resp; m_rdata <= mem[cap_ar[5:2]]; got_ar <= 0;
      end else rcd <= rcd - 1;
    end
    if (m_rvalid && m_rready) m_rvalid <= 0;
    if (sl_mute) begin got_aw <= 0; got_w <= 0; got_ar <= 0; end
  end

  // ---------------- bench helpers ----------------
  int n_chk = 0, n_bad = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  task automatic host_wr(input logic [2:0] i, input logic [15:0] v);
    @(negedge clk); hst_sel = 1; hst_wr = 1; hst_idx = i; hst_wdata = v;
    @(negedge clk); hst_sel = 0; hst_wr = 0;
  endtask

  task automatic host_rd(input logic [2:0] i, output logic [15:0] v);
    @(negedge clk); hst_sel = 1; hst_wr = 0; hst_idx = i;
    @(negedge clk); v = hst_rdata; hst_sel = 0;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    for (int t = 0; t < 100; t++) begin
      host_rd(3'd0, s);
      if (!s[6]) break;
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] s;
    logic [31:0] a, d, ea;
    int          n0;
    for (int i = 0; i < 16; i++) begin
      mem[i]     = 32'hC0DE0000 ^ (i * 32'h01010101);
      exp_mem[i] = mem[i];
    end
    repeat (4) @(negedge clk);
    rst = 0;
    repeat (2) @(negedge clk);

    // R1 reset state
    host_rd(3'd0, s); check("R1 status after reset", s, 16'h0020);
    check("R1 irq after reset", irq, 0);
    check("R1 no valid after reset", {m_awvalid, m_wvalid, m_arvalid}, 0);

    // R2 register window and R13 non-starting codes
    host_wr(3'd2, 16'h1234); host_wr(3'd3, 16'h5678);
    host_wr(3'd4, 16'h9ABC); host_wr(3'd5, 16'hDEF0);
    host_rd(3'd2, s); check("R2 addr low", s, 16'h1234);
    host_rd(3'd3, s); check("R2 addr high", s, 16'h5678);
    host_rd(3'd4, s); check("R2 wdata low", s, 16'h9ABC);
    host_rd(3'd5, s); check("R2 wdata high", s, 16'hDEF0);
    n0 = aw_cnt + ar_cnt;
    host_wr(3'd1, 16'hF800);
    host_rd(3'd1, s); check("R2 control readback", s, 16'hF800);
    host_wr(3'd1, 16'hF80C);
    host_rd(3'd0, s); check("R13 code 0xC not busy", s, 16'h0020);
    repeat (6) @(negedge clk);
    check("R13 no transaction for 0x0/0xC", aw_cnt + ar_cnt, n0);

    // R3 R4 R5 sweep over latency, address and command variant
    for (int lat = 0; lat < 4; lat++) begin
      for (int k = 0; k < 4; k++) begin
        logic [3:0] wi;
        wi = 4'(lat * 4 + k);
        a = {16'h00AB, 10'd0, wi, 2'b00};
        d = {16'h5A00 ^ (16'(wi) * 16'h1111), 16'(lat * 257 + k)};
        sl_lat = lat;
        host_wr(3'd0, 16'hF800);
        host_wr(3'd4, d[15:0]); host_wr(3'd5, d[31:16]);
        host_wr(3'd2, a[15:0]); host_wr(3'd3, a[31:16]);
        host_wr(3'd1, 16'hF808 | 16'(k[0]));
        host_rd(3'd0, s); check("R8 busy after accepted write", s[6], 1);
        wait_idle();
        exp_mem[wi] = d;
        check("R3 write address", last_aw, a);
        check("R3 write data", last_w, d);
        check("R3 strobes", m_wstrb, 4'hF);
        host_rd(3'd0, s); check("R3 write done status", s, 16'h4020);
        check("R11 irq with enabled event", irq, 1);
        ea = k[0] ? a + 32'd4 : a;
        host_rd(3'd2, s); check("R5 address after write", s, ea[15:0]);
        host_wr(3'd0, 16'hF800); host_wr(3'd2, a[15:0]);
        host_wr(3'd1, 16'hF80A | 16'(k[1]));
        wait_idle();
        host_rd(3'd0, s); check("R4 read done status", s, 16'h80A0);
        host_rd(3'd6, s); check("R4 read data low", s, exp_mem[wi][15:0]);
        host_rd(3'd7, s); check("R4 read data high", s, exp_mem[wi][31:16]);
        host_rd(3'd0, s); check("R4 available cleared by index 7", s, 16'h8020);
        ea = k[1] ? a + 32'd4 : a;
        host_rd(3'd2, s); check("R5 address after read", s, ea[15:0]);
      end
    end
    sl_lat = 1;

    // R5 carry into high half
    host_wr(3'd0, 16'hF800);
    host_wr(3'd2, 16'hFFFC); host_wr(3'd3, 16'h0012);
    host_wr(3'd4, 16'h7777); host_wr(3'd5, 16'h8888);
    host_wr(3'd1, 16'hF809); wait_idle();
    exp_mem[15] = 32'h88887777;
    host_rd(3'd2, s); check("R5 carry low", s, 16'h0000);
    host_rd(3'd3, s); check("R5 carry high", s, 16'h0013);

    // R6 error responses
    host_wr(3'd0, 16'hF800);
    host_wr(3'd2, 16'h000C); host_wr(3'd3, 16'h00AB);
    host_wr(3'd4, 16'hBEEF); host_wr(3'd5, 16'hDEAD);
    sl_resp = 2'b10;
    host_wr(3'd1, 16'hF809); wait_idle();
    host_rd(3'd0, s); check("R6 SLVERR write status", s, 16'h1020);
    host_rd(3'd2, s); check("R6 no step on error", s, 16'h000C);
    sl_resp = 2'b00;
    host_wr(3'd0, 16'hF800);
    host_wr(3'd1, 16'hF80A); wait_idle();
    host_rd(3'd6, s); check("R6 failed write left target", s, exp_mem[3][15:0]);
    host_rd(3'd7, s);
    sl_resp = 2'b11;
    host_wr(3'd0, 16'hF800);
    host_wr(3'd1, 16'hF80B); wait_idle();
    host_rd(3'd0, s); check("R6 DECERR read status", s, 16'h1020);
    host_rd(3'd6, s); check("R6 read data kept low", s, exp_mem[3][15:0]);
    host_rd(3'd7, s); check("R6 read data kept high", s, exp_mem[3][31:16]);
    host_rd(3'd2, s); check("R6 no step on read error", s, 16'h000C);
    sl_resp = 2'b00;

    // R7 R8 timeout and ignored command while busy
    host_wr(3'd0, 16'hF800);
    sl_mute = 1;
    n0 = aw_cnt;
    host_wr(3'd1, 16'hF80A);
    host_wr(3'd1, 16'hF808);
    host_rd(3'd0, s); check("R8 busy during wait", s[6], 1);
    wait_idle();
    host_rd(3'd0, s); check("R7 timeout status", s, 16'h2020);
    check("R7 valids dropped", {m_arvalid, m_awvalid, m_wvalid}, 0);
    check("R8 command while busy ignored", aw_cnt, n0);
    sl_mute = 0;

    // R10 disabled events
    host_wr(3'd0, 16'hF800);
    host_wr(3'd2, 16'h0000);
    host_wr(3'd1, 16'h0008); wait_idle();
    exp_mem[0] = 32'hDEADBEEF;
    host_rd(3'd0, s); check("R10 no event when disabled", s, 16'h0020);
    check("R10 irq low when disabled", irq, 0);

    // R9 R11 per-bit clear and interrupt gating
    host_wr(3'd1, 16'hF808); wait_idle();
    host_wr(3'd1, 16'hF80A); wait_idle();
    host_rd(3'd0, s); check("R9 two events recorded", s, 16'hC0A0);
    host_wr(3'd1, 16'h0000);
    check("R11 irq low with enables cleared", irq, 0);
    host_rd(3'd0, s); check("R11 events kept when enables cleared", s, 16'hC0A0);
    host_wr(3'd1, 16'hF800);
    check("R11 irq back with enables", irq, 1);
    host_wr(3'd0, 16'h4000);
    host_rd(3'd0, s); check("R9 clear only bit 14", s, 16'h80A0);
    check("R11 irq with one event left", irq, 1);
    host_wr(3'd0, 16'h8000);
    host_rd(3'd0, s); check("R9 clear bit 15", s, 16'h00A0);
    check("R11 irq low after clear", irq, 0);

    // R12 external interrupt
    host_wr(3'd1, 16'h0800);
    ext_irq = 1; @(negedge clk); @(negedge clk); ext_irq = 0;
    host_rd(3'd0, s); check("R12 external event sticky", s[11], 1);
    check("R12 irq from external", irq, 1);
    host_wr(3'd0, 16'h0800);
    host_wr(3'd1, 16'h0000);
    ext_irq = 1; @(negedge clk); @(negedge clk); ext_irq = 0;
    host_rd(3'd0, s); check("R10 external ignored when disabled", s[11], 0);

    summary();
    $finish;
  end
endmodule